// File: doc/BRIEF.md
# Programmable PCM Timeslot Port

This block connects eight internal byte channels to a serial PCM bus. The bus bit clock drives the block directly, and the block runs as a slave to it. An external frame pulse sets the bit position inside a frame. The frame holds a programmable number of 8-bit slots, which it counts continuously. Each channel has an assignment register with a two-bit mode and a slot number. While a slot owned by a channel passes, the port shifts that channel's transmit byte onto the serial output and raises the output enable. In the same slot it gathers eight received bits from the serial input into a byte tagged with the channel number. An external pad cell turns the data/enable pair into a tri-state pin.

Assignment writes land in a shadow copy, which is promoted at the next frame start, so a slot is never split between owners. A write to one channel leaves every other channel's assignment unchanged. The frame length field is taken at frame start as well. A frame pulse that comes at the wrong point realigns the counters and raises a one-cycle framing-error pulse. So does a frame end that passes with no pulse.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is asserted and on its release, `pcm_dout_oe`, `pcm_dout`, `rx_valid` and `frame_err` are 0.
- R2: The frame holds `cfg_last_slot`+1 slots of 8 bit periods each. A field value below 3 counts as 3, so a frame has at least 4 slots. The field is taken at each frame start and holds for the whole frame.
- R3: When `pcm_fsync` is sampled high at a rising edge, the bit period that follows is bit 7 (MSB) of slot 0. Slot s covers bit periods 8s to 8s+7 after that edge.
- R4: `pcm_dout_oe` is 1 for all eight bit periods of a slot that an enabled channel owns, and 0 everywhere else. It stays 0 until the first frame pulse. `pcm_dout` is 0 whenever `pcm_dout_oe` is 0.
- R5: Transmit data goes out MSB first and changes on rising edges. The byte for channel c is `tx_data[8c+7:8c]`, taken at the rising edge that starts its slot.
- R6: `pcm_din` is sampled on the falling edge of each bit period of an owned slot, MSB first. In the bit period after the slot's last bit, `rx_valid` is high for one cycle, together with the byte on `rx_byte` and the owner on `rx_ch`.
- R7: A write with `cfg_wr`=1 sets the mode and slot of channel `cfg_wr_ch`. The new value takes effect from the next frame start. No other channel's assignment changes.
- R8: When several enabled channels hold the same slot, the lowest channel index owns it.
- R9: `frame_err` pulses for one cycle in two cases, after the first frame pulse: a pulse arrives anywhere other than the last bit of the frame, or the last bit passes with no pulse. The slot counter follows the pulse in both cases.
- R10: A channel owns its slot only when its mode is binary 10. Modes 00, 01 and 11 leave the slot unowned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_fsync | input | 1 | Frame pulse, one bit period wide, in the last bit before slot 0 |
| pcm_din | input | 1 | Serial receive data |
| pcm_dout | output | 1 | Serial transmit data |
| pcm_dout_oe | output | 1 | Drive enable for the transmit pin |
| cfg_last_slot | input | 6 | Slots per frame minus one |
| cfg_wr | input | 1 | Assignment write strobe |
| cfg_wr_ch | input | 3 | Channel being written |
| cfg_wr_mode | input | 2 | Channel mode (10 = on the PCM bus) |
| cfg_wr_slot | input | 6 | Slot number for the channel |
| tx_data | input | 64 | Transmit bytes, channel c in bits 8c+7:8c |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| rx_ch | output | 3 | Channel of the received byte |
| frame_err | output | 1 | Framing error pulse |

## Verification
The bench builds the block with its defaults: eight channels and a 6-bit slot field. This makes every frame length from the clamped 4-slot minimum up to 64 slots reachable, and it lets all eight channels collide on one slot. Directed phases cover these cases:
- the silent period before the first frame pulse;
- short clamped frames with duplicate and non-PCM channel modes;
- assignment rewrites in the middle of a frame;
- early and missing frame pulses.

A long random phase then varies the frame length, the assignments and the data, with rare framing faults mixed in.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int unsigned SLOT_W   = 6;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BIT_W    = $clog2(BYTE_W);
  localparam int unsigned MIN_LAST = 3;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ALT = 2'b01,
    MODE_PCM = 2'b10,
    MODE_RSV = 2'b11
  } ch_mode_e;

  typedef struct packed {
    ch_mode_e            mode;
    logic [SLOT_W-1:0]   slot;
  } slot_asg_t;

  function automatic logic [SLOT_W-1:0] clamp_last(input logic [SLOT_W-1:0] v);
    return (v < SLOT_W'(MIN_LAST)) ? SLOT_W'(MIN_LAST) : v;
  endfunction

  function automatic logic owns_slot(input slot_asg_t a, input logic [SLOT_W-1:0] s);
    return (a.mode == MODE_PCM) && (a.slot == s);
  endfunction
endpackage

// File: rtl/pcm_slot_counter.sv
module pcm_slot_counter
  import pcm_slot_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fsync,
  input  logic [SLOT_W-1:0]   cfg_last,
  output logic [SLOT_W-1:0]   cur_slot,
  output logic [BIT_W-1:0]    cur_bit,
  output logic [SLOT_W-1:0]   cur_last,
  output logic                locked,
  output logic [SLOT_W-1:0]   nxt_slot,
  output logic [BIT_W-1:0]    nxt_bit,
  output logic                nxt_frame_start,
  output logic                frame_err
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic at_end;
  logic err_now;

  always_comb begin
    at_end = (cur_bit == LAST_BIT) && (cur_slot == cur_last);
    if (fsync) begin
      nxt_slot = '0;
      nxt_bit  = '0;
    end else if (cur_bit == LAST_BIT) begin
      nxt_bit  = '0;
      nxt_slot = at_end ? '0 : cur_slot + 1'b1;
    end else begin
      nxt_bit  = cur_bit + 1'b1;
      nxt_slot = cur_slot;
    end
    nxt_frame_start = (nxt_slot == '0) && (nxt_bit == '0);
    err_now = locked && (fsync ? !at_end : at_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot  <= '0;
      cur_bit   <= '0;
      cur_last  <= '1;
      locked    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      cur_slot  <= nxt_slot;
      cur_bit   <= nxt_bit;
      frame_err <= err_now;
      if (nxt_frame_start) cur_last <= clamp_last(cfg_last);
      if (fsync)           locked   <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_slot_map.sv
module pcm_slot_map
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [1:0]          wr_mode,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic                apply,
  input  logic [SLOT_W-1:0]   look_slot,
  output logic                hit,
  output logic [CH_W-1:0]     hit_ch
);
  slot_asg_t        shadow [NCH];
  slot_asg_t        active [NCH];
  logic [NCH-1:0]   match;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    slot_asg_t sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[g] <= '{mode: MODE_OFF, slot: '0};
        active[g] <= '{mode: MODE_OFF, slot: '0};
      end else begin
        if (apply) active[g] <= shadow[g];
        if (wr_en && (wr_ch == CH_W'(g)))
          shadow[g] <= '{mode: ch_mode_e'(wr_mode), slot: wr_slot};
      end
    end

    assign sel      = apply ? shadow[g] : active[g];
    assign match[g] = owns_slot(sel, look_slot);
  end

  always_comb begin
    hit    = 1'b0;
    hit_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        hit_ch = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/pcm_slot_shift.sv
module pcm_slot_shift
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  grant,
  input  logic [CH_W-1:0]       grant_ch,
  input  logic [NCH*BYTE_W-1:0] tx_flat,
  input  logic [BIT_W-1:0]      cur_bit,
  input  logic                  din,
  output logic                  dout,
  output logic                  dout_oe,
  output logic                  rx_valid,
  output logic [BYTE_W-1:0]     rx_byte,
  output logic [CH_W-1:0]       rx_ch
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] pick;
  logic [CH_W-1:0]   own_ch;
  logic              din_fall;

  assign pick = grant ? tx_flat[int'(grant_ch)*BYTE_W +: BYTE_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      own_ch  <= '0;
    end else if (load) begin
      dout    <= pick[BYTE_W-1];
      tx_sh   <= {pick[BYTE_W-2:0], 1'b0};
      dout_oe <= grant;
      own_ch  <= grant_ch;
    end else begin
      dout    <= tx_sh[BYTE_W-1];
      tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) din_fall <= 1'b0;
    else        din_fall <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_ch    <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (dout_oe) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], din_fall};
        if (cur_bit == LAST_BIT) begin
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh[BYTE_W-2:0], din_fall};
          rx_ch    <= own_ch;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NCH  = 8,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pcm_fsync,
  input  logic                  pcm_din,
  output logic                  pcm_dout,
  output logic                  pcm_dout_oe,
  input  logic [SLOT_W-1:0]     cfg_last_slot,
  input  logic                  cfg_wr,
  input  logic [CH_W-1:0]       cfg_wr_ch,
  input  logic [1:0]            cfg_wr_mode,
  input  logic [SLOT_W-1:0]     cfg_wr_slot,
  input  logic [NCH*BYTE_W-1:0] tx_data,
  output logic                  rx_valid,
  output logic [BYTE_W-1:0]     rx_byte,
  output logic [CH_W-1:0]       rx_ch,
  output logic                  frame_err
);
  logic [SLOT_W-1:0] cur_slot, cur_last, nxt_slot;
  logic [BIT_W-1:0]  cur_bit, nxt_bit;
  logic              locked, nxt_frame_start;
  logic              map_hit, grant, slot_load;
  logic [CH_W-1:0]   map_ch;

  pcm_slot_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .fsync(pcm_fsync), .cfg_last(cfg_last_slot),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .cur_last(cur_last), .locked(locked),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_frame_start(nxt_frame_start),
    .frame_err(frame_err)
  );

  pcm_slot_map #(.NCH(NCH), .CH_W(CH_W)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_ch(cfg_wr_ch),
    .wr_mode(cfg_wr_mode), .wr_slot(cfg_wr_slot), .apply(nxt_frame_start),
    .look_slot(nxt_slot), .hit(map_hit), .hit_ch(map_ch)
  );

  assign grant     = map_hit && (pcm_fsync || locked);
  assign slot_load = (nxt_bit == '0);

  pcm_slot_shift #(.NCH(NCH), .CH_W(CH_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(slot_load), .grant(grant), .grant_ch(map_ch),
    .tx_flat(tx_data), .cur_bit(cur_bit), .din(pcm_din), .dout(pcm_dout),
    .dout_oe(pcm_dout_oe), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ch(rx_ch)
  );
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk
  import pcm_slot_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pcm_fsync,
  input logic              pcm_dout,
  input logic              pcm_dout_oe,
  input logic              rx_valid,
  input logic              frame_err,
  input logic              locked,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [SLOT_W-1:0] cur_last,
  input logic [BIT_W-1:0]  cur_bit
);
  AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !pcm_dout_oe); // R4
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_dout_oe |-> !pcm_dout); // R4
  AST_OE_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit != '0) |-> $stable(pcm_dout_oe)); // R4
  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cur_slot <= cur_last); // R2
  AST_LAST_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    cur_last >= SLOT_W'(MIN_LAST)); // R2
  AST_FSYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_fsync |=> (cur_slot == '0) && (cur_bit == '0)); // R3
  AST_RX_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(cur_bit) == BIT_W'(BYTE_W - 1)) && $past(pcm_dout_oe)); // R6
  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(locked)); // R9
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pcm_fsync(pcm_fsync), .pcm_dout(pcm_dout),
  .pcm_dout_oe(pcm_dout_oe), .rx_valid(rx_valid), .frame_err(frame_err),
  .locked(locked), .cur_slot(cur_slot), .cur_last(cur_last), .cur_bit(cur_bit)
);

// File: tb/sim_pcm_slot_port.sv
`timescale 1ns/1ps
module sim_pcm_slot_port;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pcm_fsync = 1'b0, pcm_din = 1'b0;
  logic pcm_dout, pcm_dout_oe, rx_valid, frame_err;
  logic [5:0] cfg_last_slot = '0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_wr_ch = '0;
  logic [1:0] cfg_wr_mode = '0;
  logic [5:0] cfg_wr_slot = '0;
  logic [NCH*8-1:0] tx_data = '0;
  logic [7:0] rx_byte;
  logic [2:0] rx_ch;

  int n_checks = 0, n_errs = 0;
  string ph = "R1";

  // reference state
  bit m_locked, m_hit;
  int m_slot, m_bit, m_last, m_ch;
  logic [7:0] m_byte, m_rx;
  int sh_mode[NCH], sh_slot[NCH], ac_mode[NCH], ac_slot[NCH];
  bit e_oe, e_dout, e_rxv, e_err;
  logic [7:0] e_rxb;
  int e_rxc;

  pcm_slot_port u0 (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, ph, act, exp, $time);
    end
  endtask

  function automatic int clampl(input int v);
    return (v < 3) ? 3 : v;
  endfunction

  function automatic int owner(input int s, input bit from_shadow);
    for (int c = 0; c < NCH; c++) begin
      int md, sl;
      md = from_shadow ? sh_mode[c] : ac_mode[c];
      sl = from_shadow ? sh_slot[c] : ac_slot[c];
      if (md == 2 && sl == s) return c;
    end
    return -1;
  endfunction

  function automatic bit frame_end();
    return (m_bit == 7) && (m_slot == m_last);
  endfunction

  // Called in the middle of a bit period: drive, predict next period, check it.
  task automatic step(input bit fs, input bit wr, input int ch, input int md, input int sl);
    int ns, nb, own;
    bit fstart;
    pcm_fsync = fs; pcm_din = 1'($urandom);
    tx_data = {$urandom, $urandom};
    cfg_wr = wr; cfg_wr_ch = 3'(ch); cfg_wr_mode = 2'(md); cfg_wr_slot = 6'(sl);
    e_rxv = 0;
    if (m_hit) begin
      m_rx = {m_rx[6:0], pcm_din};
      if (m_bit == 7) begin e_rxv = 1; e_rxb = m_rx; e_rxc = m_ch; end
    end
    e_err = m_locked && (fs ? !frame_end() : frame_end());
    if (fs) begin ns = 0; nb = 0; end
    else if (m_bit == 7) begin nb = 0; ns = frame_end() ? 0 : m_slot + 1; end
    else begin nb = m_bit + 1; ns = m_slot; end
    fstart = (ns == 0) && (nb == 0);
    if (nb == 0) begin
      own = owner(ns, fstart);
      m_hit = (own >= 0) && (fs || m_locked);
      m_ch = m_hit ? own : 0;
      m_byte = m_hit ? tx_data[own*8 +: 8] : 8'h00;
    end
    e_oe = m_hit;
    e_dout = m_byte[7 - nb];
    if (fstart) begin
      m_last = clampl(int'(cfg_last_slot));
      for (int c = 0; c < NCH; c++) begin ac_mode[c] = sh_mode[c]; ac_slot[c] = sh_slot[c]; end
    end
    if (fs) m_locked = 1;
    if (wr) begin sh_mode[ch] = md; sh_slot[ch] = sl; end
    m_slot = ns; m_bit = nb;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    check(pcm_dout_oe == e_oe, "R4", int'(pcm_dout_oe), int'(e_oe));
    check(pcm_dout == e_dout, "R5", int'(pcm_dout), int'(e_dout));
    check(rx_valid == e_rxv, "R6", int'(rx_valid), int'(e_rxv));
    if (e_rxv) begin
      check(rx_byte == e_rxb, "R6", int'(rx_byte), int'(e_rxb));
      check(int'(rx_ch) == e_rxc, "R6", int'(rx_ch), e_rxc);
    end
    check(frame_err == e_err, "R9", int'(frame_err), int'(e_err));
  endtask

  task automatic run(input int n, input int flip_pm, input int wr_pm, input int max_slot);
    for (int i = 0; i < n; i++) begin
      bit fs, wr;
      int md;
      fs = frame_end();
      if (int'($urandom % 1000) < flip_pm) fs = !fs;
      wr = int'($urandom % 1000) < wr_pm;
      md = ($urandom % 4 == 0) ? int'($urandom % 4) : 2;
      step(fs, wr, int'($urandom % NCH), md, int'($urandom % (max_slot + 1)));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_locked = 0; m_hit = 0; m_slot = 0; m_bit = 0; m_last = 63; m_ch = 0;
    m_byte = 0; m_rx = 0;
    for (int c = 0; c < NCH; c++) begin sh_mode[c] = 0; sh_slot[c] = 0; ac_mode[c] = 0; ac_slot[c] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check(pcm_dout_oe == 0, "R1", int'(pcm_dout_oe), 0);
    check(pcm_dout == 0, "R1", int'(pcm_dout), 0);
    check(rx_valid == 0, "R1", int'(rx_valid), 0);
    check(frame_err == 0, "R1", int'(frame_err), 0);
    rst_n = 1'b1;
    // before any frame pulse: assignments written, output must stay silent
    ph = "R4 prelock";
    cfg_last_slot = 6'd1;
    step(0, 1, 0, 2, 0);
    step(0, 1, 1, 2, 3);
    step(0, 1, 2, 1, 1);
    step(0, 1, 5, 2, 3);
    step(0, 1, 7, 2, 2);
    step(0, 1, 4, 3, 2);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0);
    // lock, clamped 4-slot frames, duplicate owner, non-PCM modes
    ph = "R2 R3 R8 R10";
    step(1, 0, 0, 0, 0);
    run(4 * 32, 0, 0, 3);
    // live rewrites in the middle of frames
    ph = "R7";
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 13; i++) step(frame_end(), 0, 0, 0, 0);
      step(0, 1, f, (f == 1) ? 0 : 2, f + 1);
      run(40, 0, 0, 3);
    end
    cfg_last_slot = 6'd7;
    run(200, 0, 0, 7);
    // early and missing frame pulses
    ph = "R9";
    for (int i = 0; i < 10; i++) step(frame_end(), 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    run(100, 0, 0, 7);
    while (!frame_end()) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    run(150, 5, 0, 7);
    // full-length frames
    ph = "R2 max";
    cfg_last_slot = 6'd63;
    run(1100, 0, 20, 63);
    // random mix
    ph = "R3 random";
    for (int k = 0; k < 40; k++) begin
      cfg_last_slot = 6'($urandom % 64);
      run(600, 1, 15, int'(cfg_last_slot) < 3 ? 3 : int'(cfg_last_slot));
    end
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog [%s] actual=timeout expected=done", ph);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule